// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block computes the lane-enable mask for a vector datapath whose register width is fixed when the design is configured. The width is a multiple of 128 bits and may be as large as 2048 bits. A caller supplies four things: a start strobe, an element size, a pattern selector and the vector length the hardware currently runs at. One clock later the block returns a predicate word with one bit per byte lane. It also returns a one-cycle done pulse and a flag that tells whether any lane came out enabled. Downstream vector operations process only the element positions that are enabled.

The mask is never hard-wired: it follows the runtime vector length. A "whole register" pattern enables every element of the chosen size that fits. A fixed-count pattern enables exactly that many low elements. If the register is too short to hold the requested count, the fixed-count pattern enables nothing, and the count is never cut down to the register size.

Start and done are plain control pins with no back-pressure. The consumer must take the result while it is held. The predicate register keeps its value until the next start.

Top module: `vpred_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no start seen, `pred` is all zero and `done` and `any_active` are low.
- R2: `done` is high for exactly one cycle, one clock after a cycle with `start` high. `esize`, `pattern` and `vl_bytes` are sampled only in the start cycle. `pred` and `any_active` keep their values until the next start.
- R3: Pattern code 0 (whole register) enables element positions 0 to `floor(VL / E) - 1`. Here VL is the effective vector length in bytes, and E is the element size in bytes: 1, 2, 4 or 8 for `esize` codes 0, 1, 2 and 3.
- R4: Pattern codes 1, 2 and 3 request a fixed count of 16, 32 or 64 elements. When `floor(VL / E)` is at least the count, exactly element positions 0 to count-1 are enabled.
- R5: When a fixed count exceeds `floor(VL / E)`, every predicate bit is zero. The count is not clamped.
- R6: Element position k maps to predicate bit k*E. Every bit whose index is not a multiple of E is zero.
- R7: Enabled elements form one run that starts at position 0. Every predicate bit at index VL or above is zero.
- R8: `any_active` is high exactly when at least one bit of `pred` is set.
- R9: The effective length VL is `vl_bytes` rounded down to a multiple of 16. If `vl_bytes` exceeds `MAX_VL_BYTES`, VL is `MAX_VL_BYTES` instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Compute a new mask from the inputs this cycle |
| esize | input | 2 | Element size code: 0=8, 1=16, 2=32, 3=64 bits |
| pattern | input | 2 | 0=whole register, 1=count 16, 2=count 32, 3=count 64 |
| vl_bytes | input | $clog2(MAX_VL_BYTES)+1 | Current vector length in bytes |
| pred | output | MAX_VL_BYTES | Predicate, one bit per byte lane |
| done | output | 1 | One-cycle pulse when `pred` is updated |
| any_active | output | 1 | At least one predicate bit is set |

## Verification
The hardest case to reach is the boundary between a fixed-count pattern that just fits and one that just misses. Examples are a count of 64 with 64-bit elements, which needs exactly 512 bytes and so can never fit at the default maximum. Another is a count of 32 with bytes at a length of 31 versus 32. Both sides must be hit at each element size, together with lengths that are not multiples of 16 and lengths above the maximum. The stimulus reaches all of them by sweeping every length value the input can encode against every size and pattern code. Input changes without a start are also applied between results, to show the held mask does not move.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
  typedef enum logic [1:0] {ESZ_B = 2'd0, ESZ_H = 2'd1, ESZ_W = 2'd2, ESZ_D = 2'd3} esz_e;
  typedef enum logic [1:0] {PAT_ALL = 2'd0, PAT_C16 = 2'd1, PAT_C32 = 2'd2, PAT_C64 = 2'd3} pat_e;

  // Requested element count of a fixed-count pattern (0 for whole register)
  function automatic int unsigned pat_count(pat_e p);
    case (p)
      PAT_C16: return 16;
      PAT_C32: return 32;
      PAT_C64: return 64;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/vpred_vl_sanitize.sv
module vpred_vl_sanitize #(
  parameter int unsigned MAX_VL_BYTES = 256,
  parameter int unsigned GRAN_BYTES   = 16,
  localparam int unsigned VLW  = $clog2(MAX_VL_BYTES) + 1,
  localparam int unsigned LOWB = $clog2(GRAN_BYTES)
) (
  input  logic [VLW-1:0] vl_raw,
  output logic [VLW-1:0] vl_eff
);
  localparam logic [VLW-1:0] MAXV = VLW'(MAX_VL_BYTES);

  always_comb begin
    if (vl_raw > MAXV) vl_eff = MAXV;
    else               vl_eff = {vl_raw[VLW-1:LOWB], {LOWB{1'b0}}};
  end
endmodule

// File: rtl/vpred_elem_count.sv
module vpred_elem_count
  import vpred_pkg::*;
#(
  parameter int unsigned MAX_VL_BYTES = 256,
  localparam int unsigned VLW = $clog2(MAX_VL_BYTES) + 1
) (
  input  logic [VLW-1:0] vl_eff,
  input  esz_e           esz,
  input  pat_e           pat,
  output logic [VLW-1:0] n_active
);
  logic [VLW-1:0] fit;
  logic [VLW-1:0] want;

  always_comb begin
    fit  = vl_eff >> esz;
    want = VLW'(pat_count(pat));
    if (pat == PAT_ALL)   n_active = fit;
    else if (fit >= want) n_active = want;
    else                  n_active = '0;
  end
endmodule

// File: rtl/vpred_lane_mask.sv
module vpred_lane_mask
  import vpred_pkg::*;
#(
  parameter int unsigned MAX_VL_BYTES = 256,
  localparam int unsigned VLW   = $clog2(MAX_VL_BYTES) + 1,
  localparam int unsigned LANES = MAX_VL_BYTES
) (
  input  esz_e             esz,
  input  logic [VLW-1:0]   n_active,
  output logic [LANES-1:0] mask
);
  logic [VLW-1:0] sub_mask;
  assign sub_mask = (VLW'(1) << esz) - VLW'(1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [VLW-1:0] IDX = VLW'(i);
    assign mask[i] = ((IDX & sub_mask) == '0) && ((IDX >> esz) < n_active);
  end
endmodule

// File: rtl/vpred_gen.sv
module vpred_gen
  import vpred_pkg::*;
#(
  parameter int unsigned MAX_VL_BYTES = 256,
  parameter int unsigned GRAN_BYTES   = 16,
  localparam int unsigned VLW   = $clog2(MAX_VL_BYTES) + 1,
  localparam int unsigned LANES = MAX_VL_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       esize,
  input  logic [1:0]       pattern,
  input  logic [VLW-1:0]   vl_bytes,
  output logic [LANES-1:0] pred,
  output logic             done,
  output logic             any_active
);
  logic [VLW-1:0]   vl_eff;
  logic [VLW-1:0]   n_active;
  logic [LANES-1:0] mask_d;
  esz_e             esz;
  pat_e             pat;

  assign esz = esz_e'(esize);
  assign pat = pat_e'(pattern);

  vpred_vl_sanitize #(.MAX_VL_BYTES(MAX_VL_BYTES), .GRAN_BYTES(GRAN_BYTES)) u_vl (
    .vl_raw (vl_bytes),
    .vl_eff (vl_eff)
  );

  vpred_elem_count #(.MAX_VL_BYTES(MAX_VL_BYTES)) u_cnt (
    .vl_eff   (vl_eff),
    .esz      (esz),
    .pat      (pat),
    .n_active (n_active)
  );

  vpred_lane_mask #(.MAX_VL_BYTES(MAX_VL_BYTES)) u_mask (
    .esz      (esz),
    .n_active (n_active),
    .mask     (mask_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred       <= '0;
      done       <= 1'b0;
      any_active <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        pred       <= mask_d;
        any_active <= (n_active != '0);
      end
    end
  end
endmodule

// File: rtl/vpred_chk.sv
module vpred_chk #(
  parameter int unsigned MAX_VL_BYTES = 256,
  parameter int unsigned GRAN_BYTES   = 16,
  localparam int unsigned VLW   = $clog2(MAX_VL_BYTES) + 1,
  localparam int unsigned LANES = MAX_VL_BYTES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       esize,
  input logic [1:0]       pattern,
  input logic [VLW-1:0]   vl_bytes,
  input logic [LANES-1:0] pred,
  input logic             done,
  input logic             any_active
);
  function automatic int unsigned eff_len(logic [VLW-1:0] v);
    if (int'(v) > MAX_VL_BYTES) return MAX_VL_BYTES;
    return (int'(v) / GRAN_BYTES) * GRAN_BYTES;
  endfunction

  function automatic logic [LANES-1:0] lead_bits(logic [1:0] e);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = ((i % (1 << e)) == 0);
    return m;
  endfunction

  function automatic logic too_short(logic [1:0] p, logic [1:0] e, logic [VLW-1:0] v);
    if (p == 2'd0) return 1'b0;
    return (eff_len(v) >> e) < (8 << p);
  endfunction

  // R2
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> done);
  // R2
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(start));
  // R2
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(pred) && $stable(any_active)));
  // R5
  no_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && too_short(pattern, esize, vl_bytes) |=> (pred == '0));
  // R6
  lead_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pred & ~lead_bits($past(esize))) == '0));
  // R7
  above_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pred >> eff_len($past(vl_bytes))) == '0));
  // R8
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_active == (pred != '0));
endmodule

bind vpred_gen vpred_chk #(.MAX_VL_BYTES(MAX_VL_BYTES), .GRAN_BYTES(GRAN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .esize(esize), .pattern(pattern),
  .vl_bytes(vl_bytes), .pred(pred), .done(done), .any_active(any_active)
);

// File: tb/sim_vpred_gen.sv
`timescale 1ns/1ps
module sim_vpred_gen;
  localparam int MAXB  = 256;
  localparam int VLW   = $clog2(MAXB) + 1;
  localparam int LANES = MAXB;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       esize = '0;
  logic [1:0]       pattern = '0;
  logic [VLW-1:0]   vl_bytes = '0;
  logic [LANES-1:0] pred;
  logic             done;
  logic             any_active;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vpred_gen #(.MAX_VL_BYTES(MAXB), .GRAN_BYTES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .esize(esize), .pattern(pattern),
    .vl_bytes(vl_bytes), .pred(pred), .done(done), .any_active(any_active)
  );

  function automatic int eff_of(int v);
    if (v > MAXB) return MAXB;
    return (v / 16) * 16;
  endfunction

  function automatic logic [LANES-1:0] model(int e, int p, int v);
    logic [LANES-1:0] m;
    int eb  = 1 << e;
    int fit = eff_of(v) / eb;
    int n;
    if (p == 0) n = fit;
    else begin
      n = 16 << (p - 1);
      if (n > fit) n = 0;
    end
    for (int i = 0; i < LANES; i++) m[i] = ((i % eb) == 0) && ((i / eb) < n);
    return m;
  endfunction

  task automatic chk(bit ok, string req, logic [LANES-1:0] act, logic [LANES-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_op(int e, int p, int v);
    logic [LANES-1:0] exp;
    logic [LANES-1:0] nonlead;
    string tag;
    exp = model(e, p, v);
    @(negedge clk);
    esize = 2'(e); pattern = 2'(p); vl_bytes = VLW'(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // change inputs after the start edge: R2 says they must not matter
    esize = ~esize; pattern = ~pattern; vl_bytes = ~vl_bytes;
    if (v > MAXB || (v % 16) != 0) tag = "R9";
    else if (p == 0) tag = "R3";
    else if (exp == '0) tag = "R5";
    else tag = "R4";
    chk(done === 1'b1, "R2 done", LANES'(done), LANES'(1));
    chk(pred === exp, tag, pred, exp);
    chk(any_active === (exp != '0), "R8 any_active", LANES'(any_active), LANES'(exp != '0));
    nonlead = '0;
    for (int i = 0; i < LANES; i++) if ((i % (1 << e)) != 0) nonlead[i] = pred[i];
    chk(nonlead == '0, "R6 non-lead bits", nonlead, '0);
    chk((pred >> eff_of(v)) == '0, "R7 above VL", pred >> eff_of(v), '0);
    @(negedge clk);
    chk(done === 1'b0, "R2 done width", LANES'(done), '0);
    chk(pred === exp, "R2 hold", pred, exp);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(pred === '0 && done === 1'b0 && any_active === 1'b0, "R1 in reset", pred, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pred === '0 && done === 1'b0 && any_active === 1'b0, "R1 after release", pred, '0);

    // directed corners: R3 320-bit-like length 40 bytes rounds to 32 (R9)
    run_op(2, 0, 40);
    run_op(0, 3, 64);   // R4 exact fit for count 64 bytes
    run_op(0, 3, 63);   // R5 one short -> rounds to 48
    run_op(0, 2, 32);   // R4
    run_op(0, 2, 31);   // R5
    run_op(3, 3, 511);  // R5 count 64 of 64-bit never fits at 256 bytes
    run_op(3, 0, 511);  // R9 clamp to max

    // R2 stability: change inputs with no start, result must stay
    begin
      logic [LANES-1:0] held;
      held = pred;
      @(negedge clk);
      esize = 2'd0; pattern = 2'd0; vl_bytes = VLW'(MAXB);
      repeat (3) @(negedge clk);
      chk(pred === held && done === 1'b0, "R2 no start", pred, held);
    end

    // near-exhaustive sweep: every length code against every size and pattern
    for (int e = 0; e < 4; e++)
      for (int p = 0; p < 4; p++)
        for (int v = 0; v < (1 << VLW); v++)
          run_op(e, p, v);

    finish_run();
  end
endmodule